// File: doc/BRIEF.md
# Pulse Width Capture Channel

This block is the input stage of one timer channel. It watches a single external input and turns its edges into timing measurements. The input is re-timed through a two-flop synchroniser and compared against its previous sample to find rising and falling edges. A free-running up-counter is restarted by the edge that opens a measurement. The edge that closes it copies the counter into a 32-bit capture data register and raises a one-cycle interrupt.

A 2-bit edge-select field picks one of four behaviours. Two of them act on a single polarity: every edge of that polarity closes one interval and opens the next, which gives the period between like edges. The other two measure the width of a low phase or a high phase: one polarity opens the measurement and the opposite polarity closes it. A separate 2-bit update-policy field decides how the overflow flag and the capture register follow new measurements. The overflow flag records that the counter wrapped through zero while a measurement was open.

Software reaches the block through a plain register port with write and read strobes. Read data is registered and is valid on the cycle after the read strobe. There is no streaming data path, so the port has no valid/ready handshake. A strobe is accepted on the cycle it is high, and the block never stalls the port.

Top module: `pwc_channel`

## Requirements
- R1: After reset the control word, the capture data register, the overflow flag, the read data and the interrupt are all zero.
- R2: With edge-select 00, each falling edge closes the interval opened by the previous falling edge and captures its length in clock cycles, then opens a new interval. Rising edges are ignored. The first falling edge after a control write only opens an interval.
- R3: With edge-select 01, the same behaviour as R2 applies to rising edges, and falling edges are ignored.
- R4: With edge-select 10, a falling edge opens a measurement and the next rising edge captures the low time in clock cycles. A rising edge with no open measurement captures nothing.
- R5: With edge-select 11, a rising edge opens a measurement and the next falling edge captures the high time in clock cycles. A falling edge with no open measurement captures nothing.
- R6: Every capture drives the interrupt output high for exactly one cycle, on the cycle after the capture register loads. Edges that capture nothing leave the interrupt low.
- R7: With update policy 00 (control bits [3:2]), the overflow flag (status bit 0) sets as soon as the counter wraps from all-ones to zero while a measurement is open. It is cleared only by writing 1 to status bit 0. Writing 0 there has no effect.
- R8: With update policy 01, the overflow flag changes only at a capture. It then takes the value that says whether that interval wrapped, so a capture with no wrap clears it.
- R9: With update policy 10 or 11, a capture locks the data register. Later closing edges neither load it nor raise the interrupt until software reads the data register. The counter still restarts on every opening edge.
- R10: A read of the data register in the same cycle as a capture returns the previous value. The new value is returned by the next read.
- R11: A write to the control register (address 0, edge-select in bits [1:0]) closes any open measurement without capturing. Register addresses: 0 control, 1 capture data, 2 status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_in | input | 1 | Raw, unsynchronised measurement input |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 capture data, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_rd |
| cap_irq | output | 1 | One-cycle capture interrupt |

## Verification
The bench counts exact cycle intervals and targets the off-by-one that a wrong counter reload would cause: every captured value must equal the number of cycles between pin changes. It checks that a stray opposite-polarity edge does not capture, since a design that ignores the open-measurement state would load a garbage width. A narrow counter forces a wrap. This separates the sticky and per-capture overflow policies: a design that mixes them would either flag the wrap early or fail to clear it on a clean measurement. The bench also aims a read into the exact capture cycle, where a read path taken from the next-state value would return the new value one cycle too early. It checks the lock policy and the control-write disarm, because a design missing either would load a later edge.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    SEL_FALL = 2'b00,
    SEL_RISE = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_HIGH = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    UPD_STICKY = 2'b00,
    UPD_PERCAP = 2'b01,
    UPD_LOCK_A = 2'b10,
    UPD_LOCK_B = 2'b11
  } upd_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/pwc_sync_edge.sv
module pwc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= ONE;
    else              cnt <= cnt + ONE;

  assign wrap = armed & ~restart & (&cnt);
endmodule

// File: rtl/pwc_arm_ctrl.sv
module pwc_arm_ctrl
  import pwc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_e sel,
  input  logic rise,
  input  logic fall,
  input  logic ctrl_wr,
  output logic restart,
  output logic stop_req,
  output logic armed
);
  logic open_edge;
  logic close_edge;
  logic width_mode;

  assign width_mode = sel[1];
  assign open_edge  = sel[0] ? rise : fall;
  assign close_edge = width_mode ? (sel[0] ? fall : rise) : open_edge;

  assign restart  = open_edge;
  assign stop_req = armed & close_edge & ~ctrl_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         armed <= 1'b0;
    else if (ctrl_wr)                   armed <= 1'b0;
    else if (open_edge)                 armed <= 1'b1;
    else if (width_mode && close_edge)  armed <= 1'b0;
endmodule

// File: rtl/pwc_regs.sv
module pwc_regs
  import pwc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              sel,
  input  upd_e              upd,
  input  logic              stop_req,
  input  logic              restart,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cap_load,
  output logic              ovf,
  output logic              irq
);
  logic [DATA_W-1:0] cap_q;
  logic              locked;
  logic              wrap_seen;
  logic              lock_mode;
  logic              data_read;
  logic              ovf_clr;

  assign lock_mode = upd[1];
  assign data_read = reg_rd && (reg_addr == ADDR_DATA);
  assign ovf_clr   = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];
  assign cap_load  = stop_req & ~(lock_mode & locked);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      cap_q <= '0;
    else if (cap_load)               cap_q <= DATA_W'(cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      locked <= 1'b0;
    else if (cap_load && lock_mode)  locked <= 1'b1;
    else if (data_read)              locked <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        wrap_seen <= 1'b0;
    else if (restart)  wrap_seen <= 1'b0;
    else if (wrap)     wrap_seen <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovf <= 1'b0;
    else if (upd == UPD_PERCAP) begin
      if (cap_load)     ovf <= wrap_seen;
      else if (ovf_clr) ovf <= 1'b0;
    end else begin
      if (wrap)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= cap_load;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= DATA_W'({upd, sel});
        ADDR_DATA: reg_rdata <= cap_q;
        ADDR_STAT: reg_rdata <= DATA_W'(ovf);
        default:   reg_rdata <= '0;
      endcase
    end
endmodule

// File: rtl/pwc_channel.sv
module pwc_channel
  import pwc_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cap_irq
);
  sel_e             sel;
  upd_e             upd;
  logic             ctrl_wr;
  logic             rise, fall;
  logic             restart, stop_req, armed;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             cap_load;
  logic             ovf;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel <= SEL_FALL;
      upd <= UPD_STICKY;
    end else if (ctrl_wr) begin
      sel <= sel_e'(reg_wdata[1:0]);
      upd <= upd_e'(reg_wdata[3:2]);
    end

  pwc_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(rise), .fall(fall)
  );

  pwc_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rise(rise), .fall(fall),
    .ctrl_wr(ctrl_wr), .restart(restart), .stop_req(stop_req), .armed(armed)
  );

  pwc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .armed(armed),
    .cnt(cnt), .wrap(wrap)
  );

  pwc_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .upd(upd), .stop_req(stop_req),
    .restart(restart), .wrap(wrap), .cnt(cnt), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cap_load(cap_load), .ovf(ovf), .irq(cap_irq)
  );
endmodule

// File: rtl/pwc_chk.sv
module pwc_chk #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_load,
  input logic              irq,
  input logic              restart,
  input logic [CNT_W-1:0]  cnt,
  input logic              wrap,
  input logic              ovf,
  input logic              armed,
  input logic              width_mode,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata
);
  // R6: a capture is followed by the interrupt
  a_r6_irq_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> irq);

  // R6: the interrupt has a capture behind it
  a_r6_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cap_load));

  // R2: an opening edge reloads the counter so the width counts whole cycles
  a_r2_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == CNT_W'(1)));

  // R7: the overflow flag only rises after a wrap or a capture
  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(wrap || cap_load));

  // R5: a width-mode capture closes the measurement
  a_r5_width_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_load && width_mode) |=> !armed);

  // R10: read data moves only in answer to a read strobe
  a_r10_rdata_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_rdata) |-> $past(reg_rd));
endmodule

bind pwc_channel pwc_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_load(cap_load), .irq(cap_irq),
  .restart(restart), .cnt(cnt), .wrap(wrap), .ovf(ovf), .armed(armed),
  .width_mode(sel[1]), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
);

// File: tb/pwc_channel_test.sv
module pwc_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cap_irq;

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0;

  always #5 clk = ~clk;

  pwc_channel #(.CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cap_irq(cap_irq)
  );

  always @(negedge clk) if (rst_n && cap_irq) irq_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(cap_irq), 0);
    rd_reg(0, v); chk("R1 ctrl", v, 0);
    rd_reg(1, v); chk("R1 data", v, 0);
    rd_reg(2, v); chk("R1 ovf", v, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v; int i0;
    wr_reg(0, 32'h0);
    i0 = irq_cnt;
    cap_in = 1; wait_cyc(5);
    cap_in = 0; wait_cyc(8);
    cap_in = 1; wait_cyc(12);
    cap_in = 0; wait_cyc(6);
    rd_reg(1, v); chk("R2 falling period", v, 20);
    chk("R6 one irq cycle", 32'(irq_cnt - i0), 1);
    chk("R6 irq low after", 32'(cap_irq), 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr_reg(0, 32'h1);
    cap_in = 1; wait_cyc(4);
    cap_in = 0; wait_cyc(29);
    cap_in = 1; wait_cyc(6);
    rd_reg(1, v); chk("R3 rising period", v, 33);
  endtask

  task automatic t_low();
    logic [31:0] v; int i0;
    cap_in = 0; wait_cyc(5);
    wr_reg(0, 32'h2);
    i0 = irq_cnt;
    cap_in = 1; wait_cyc(6);
    rd_reg(1, v); chk("R4 unarmed rise no capture", v, 33);
    chk("R6 no irq unarmed", 32'(irq_cnt - i0), 0);
    cap_in = 0; wait_cyc(17);
    cap_in = 1; wait_cyc(6);
    rd_reg(1, v); chk("R4 low width", v, 17);
  endtask

  task automatic t_high();
    logic [31:0] v;
    wr_reg(0, 32'h3);
    cap_in = 0; wait_cyc(6);
    rd_reg(1, v); chk("R5 unarmed fall no capture", v, 17);
    cap_in = 1; wait_cyc(9);
    cap_in = 0; wait_cyc(6);
    rd_reg(1, v); chk("R5 high width", v, 9);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    wr_reg(0, 32'h3);
    cap_in = 1; wait_cyc(300);
    cap_in = 0; wait_cyc(6);
    rd_reg(1, v); chk("R7 wrapped width", v, 44);
    rd_reg(2, v); chk("R7 ovf set", v, 1);
    wr_reg(2, 32'h0);
    rd_reg(2, v); chk("R7 write 0 keeps ovf", v, 1);
    wr_reg(2, 32'h1);
    rd_reg(2, v); chk("R7 write 1 clears ovf", v, 0);
  endtask

  task automatic t_percap();
    logic [31:0] v;
    wr_reg(0, 32'h7);
    cap_in = 1; wait_cyc(268);
    rd_reg(2, v); chk("R8 no flag before capture", v, 0);
    wait_cyc(31);
    cap_in = 0; wait_cyc(6);
    rd_reg(1, v); chk("R8 wrapped width", v, 44);
    rd_reg(2, v); chk("R8 flag at capture", v, 1);
    cap_in = 1; wait_cyc(20);
    cap_in = 0; wait_cyc(6);
    rd_reg(1, v); chk("R8 clean width", v, 20);
    rd_reg(2, v); chk("R8 clean capture clears", v, 0);
  endtask

  task automatic t_hold();
    logic [31:0] v; int i0;
    wr_reg(0, 32'h9);
    cap_in = 1; wait_cyc(4);
    cap_in = 0; wait_cyc(6);
    cap_in = 1; wait_cyc(5);
    cap_in = 0; wait_cyc(10);
    i0 = irq_cnt;
    cap_in = 1; wait_cyc(5);
    chk("R9 locked no irq", 32'(irq_cnt - i0), 0);
    rd_reg(1, v); chk("R9 locked value", v, 10);
    cap_in = 0; wait_cyc(9);
    cap_in = 1; wait_cyc(6);
    rd_reg(1, v); chk("R9 unlocked capture", v, 15);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr_reg(0, 32'h3);
    cap_in = 0; wait_cyc(5);
    cap_in = 1; wait_cyc(6);
    cap_in = 0;
    wait_cyc(2);
    rd_reg(1, v); chk("R10 same-cycle read old", v, 15);
    rd_reg(1, v); chk("R10 next read new", v, 6);
  endtask

  task automatic t_rearm();
    logic [31:0] v; int i0;
    i0 = irq_cnt;
    cap_in = 1; wait_cyc(5);
    wr_reg(0, 32'h3);
    wait_cyc(5);
    cap_in = 0; wait_cyc(6);
    rd_reg(1, v); chk("R11 ctrl write disarms", v, 6);
    chk("R11 no irq", 32'(irq_cnt - i0), 0);
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_fall();
    t_rise();
    t_low();
    t_high();
    t_sticky();
    t_percap();
    t_hold();
    t_collide();
    t_rearm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule